// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the 32-bit interrupt control word that sits beside a multi-channel DMA engine. Software programs it through a single write port: six low control bits, a force bit that asserts the master interrupt by itself, seven per-channel interrupt enables and a global enable. Each channel also has a completion flag. A channel's completion pulse sets its flag only while that channel's enable is on. Software clears a flag by writing a one to it.

Every cycle, the block recomputes a master flag in the top bit of the word. The flag is set when the global enable is on and at least one completion flag is set, or when the force bit is on. Toward the interrupt controller the block issues a single-cycle request, and only when the master flag goes from clear to set. While the flag stays set, no further requests are sent. When the condition goes away, the master flag drops. A later rise raises a fresh request.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the read word is 0x00000000 and the request output is low.
- R2: A write loads bits 5:0, bit 15 (force) and bits 23:16 from the write data. Bits 14:6 always read as zero and ignore written values.
- R3: Completion flags sit at bits 30:24, with channel n at bit 24+n. Writing a one clears the flag, writing a zero keeps it, and a write can never set a flag.
- R4: A completion pulse on channel n sets flag bit 24+n only when enable bit 16+n is set. The enable checked is the value after any write in the same cycle. A pulse on a disabled channel has no effect.
- R5: When a clear and a completion pulse hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 31 always equals (bit 23 AND any of bits 30:24) OR bit 15. Written values of bit 31 are ignored.
- R7: The request output is high for exactly one cycle: the cycle in which bit 31 first reads set after having read clear. It stays low while bit 31 remains set.
- R8: Bit 31 clears as soon as its condition stops holding. A later return of the condition raises a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| done_pulse | input | 7 | Per-channel completion pulses from the DMA engine |
| rd_data | output | 32 | Current register contents |
| irq_req | output | 1 | Single-cycle request to the interrupt controller |

## Verification
The hardest situation to reach is a collision on one flag in one cycle. In that cycle a software write clears the flag and re-programs its enable, while the engine pulses the same channel. The outcome then depends on both the post-write enable and the set-over-clear priority. Directed steps place a write and a pulse on the same edge, with and without the enable changing. They also cover re-arming the request by toggling the global enable while a flag is pending, and raising the force bit while the master flag is already set. A long random phase then mixes sparse clears with sparse pulses. Throughout, a behavioural model checks every cycle.

// File: rtl/dicr_pkg.sv
package dicr_pkg;

  // Next value of one completion flag: a set from the engine wins over a clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Master interrupt condition.
  function automatic logic master_cond(input logic gen, input logic any_flag, input logic force_bit);
    return (gen & any_flag) | force_bit;
  endfunction

  // Edge rule for the outgoing request.
  function automatic logic rise(input logic nxt, input logic cur);
    return nxt & ~cur;
  endfunction

endpackage

// File: rtl/dicr_fields.sv
module dicr_fields #(
  parameter int NUM_CH = 7,
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              wr_force,
  input  logic [NUM_CH-1:0] wr_chen,
  input  logic              wr_gen,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              force_q,
  output logic [NUM_CH-1:0] chen_q,
  output logic              gen_q,
  output logic              force_nx,
  output logic [NUM_CH-1:0] chen_nx,
  output logic              gen_nx
);

  logic [CTRL_W-1:0] ctrl_nx;

  always_comb begin
    ctrl_nx  = ctrl_q;
    force_nx = force_q;
    chen_nx  = chen_q;
    gen_nx   = gen_q;
    if (wr_en) begin
      ctrl_nx  = wr_ctrl;
      force_nx = wr_force;
      chen_nx  = wr_chen;
      gen_nx   = wr_gen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      force_q <= 1'b0;
      chen_q  <= '0;
      gen_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nx;
      force_q <= force_nx;
      chen_q  <= chen_nx;
      gen_q   <= gen_nx;
    end
  end

endmodule

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] done_pulse,
  input  logic [NUM_CH-1:0] chen_nx,
  output logic [NUM_CH-1:0] flags_q,
  output logic [NUM_CH-1:0] flags_nx,
  output logic [NUM_CH-1:0] set_hit,
  output logic [NUM_CH-1:0] clr_hit
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
    assign clr_hit[ch]  = wr_en & clr_bits[ch];
    assign set_hit[ch]  = done_pulse[ch] & chen_nx[ch];
    assign flags_nx[ch] = dicr_pkg::flag_next(flags_q[ch], clr_hit[ch], set_hit[ch]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[ch] <= 1'b0;
      else        flags_q[ch] <= flags_nx[ch];
    end
  end

endmodule

// File: rtl/dicr_master.sv
module dicr_master #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_nx,
  input  logic              force_nx,
  input  logic [NUM_CH-1:0] flags_nx,
  output logic              master_q,
  output logic              master_nx,
  output logic              master_rise,
  output logic              irq_q
);

  logic any_flag_nx;

  assign any_flag_nx = |flags_nx;
  assign master_nx   = dicr_pkg::master_cond(gen_nx, any_flag_nx, force_nx);
  assign master_rise = dicr_pkg::rise(master_nx, master_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      master_q <= master_nx;
      irq_q    <= master_rise;
    end
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH = 7,
  parameter int CTRL_W = 6,
  localparam int REG_W = 2 * NUM_CH + 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] done_pulse,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_req
);

  localparam int FORCE_POS  = 15;
  localparam int RSV_W      = FORCE_POS - CTRL_W;
  localparam int EN_LSB     = FORCE_POS + 1;
  localparam int GEN_POS    = EN_LSB + NUM_CH;
  localparam int FLAG_LSB   = GEN_POS + 1;
  localparam int MASTER_POS = FLAG_LSB + NUM_CH;

  // Write-side decode
  logic [CTRL_W-1:0] wr_ctrl;
  logic              wr_force;
  logic [NUM_CH-1:0] wr_chen;
  logic              wr_gen;
  logic [NUM_CH-1:0] wr_clr;

  assign wr_ctrl  = wr_data[CTRL_W-1:0];
  assign wr_force = wr_data[FORCE_POS];
  assign wr_chen  = wr_data[EN_LSB +: NUM_CH];
  assign wr_gen   = wr_data[GEN_POS];
  assign wr_clr   = wr_data[FLAG_LSB +: NUM_CH];

  // Named internal events
  logic [CTRL_W-1:0] ctrl_q;
  logic              force_q, gen_q, force_nx, gen_nx;
  logic [NUM_CH-1:0] chen_q, chen_nx;
  logic [NUM_CH-1:0] flags_q, flags_nx, set_hit, clr_hit;
  logic              master_q, master_nx, master_rise;

  dicr_fields #(.NUM_CH(NUM_CH), .CTRL_W(CTRL_W)) u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ctrl  (wr_ctrl),
    .wr_force (wr_force),
    .wr_chen  (wr_chen),
    .wr_gen   (wr_gen),
    .ctrl_q   (ctrl_q),
    .force_q  (force_q),
    .chen_q   (chen_q),
    .gen_q    (gen_q),
    .force_nx (force_nx),
    .chen_nx  (chen_nx),
    .gen_nx   (gen_nx)
  );

  dicr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .clr_bits   (wr_clr),
    .done_pulse (done_pulse),
    .chen_nx    (chen_nx),
    .flags_q    (flags_q),
    .flags_nx   (flags_nx),
    .set_hit    (set_hit),
    .clr_hit    (clr_hit)
  );

  dicr_master #(.NUM_CH(NUM_CH)) u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_nx      (gen_nx),
    .force_nx    (force_nx),
    .flags_nx    (flags_nx),
    .master_q    (master_q),
    .master_nx   (master_nx),
    .master_rise (master_rise),
    .irq_q       (irq_req)
  );

  assign rd_data[CTRL_W-1:0]             = ctrl_q;
  assign rd_data[FORCE_POS-1:CTRL_W]     = {RSV_W{1'b0}};
  assign rd_data[FORCE_POS]              = force_q;
  assign rd_data[EN_LSB +: NUM_CH]       = chen_q;
  assign rd_data[GEN_POS]                = gen_q;
  assign rd_data[FLAG_LSB +: NUM_CH]     = flags_q;
  assign rd_data[MASTER_POS]             = master_q;

endmodule

// File: rtl/dicr_chk.sv
module dicr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        irq_req,
  input logic [6:0]  set_hit,
  input logic [6:0]  clr_hit
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14:6] == 9'd0); // R2

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en) |-> (rd_data[23:15] == $past(wr_data[23:15]))
                            && (rd_data[5:0] == $past(wr_data[5:0]))); // R2

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rd_data[30:24] & $past(clr_hit) & ~$past(set_hit)) == 7'd0); // R3

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rd_data[30:24] & $past(set_hit)) == $past(set_hit)); // R4

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rd_data[30:24] & ~$past(rd_data[30:24]) & ~$past(set_hit)) == 7'd0); // R5

  AST_MASTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == ((rd_data[23] && (rd_data[30:24] != 7'd0)) || rd_data[15])); // R6

  AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_req == (rd_data[31] && !$past(rd_data[31]))); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req); // R8

endmodule

bind dma_irq_ctrl dicr_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq_req (irq_req),
  .set_hit (set_hit),
  .clr_hit (clr_hit)
);

// File: tb/sim_dma_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  done_pulse = '0;
  logic [31:0] rd_data;
  logic        irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [31:0] m_reg = '0;
  logic        m_irq = 1'b0;

  always #2 clk = ~clk;

  dma_irq_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .done_pulse (done_pulse),
    .rd_data    (rd_data),
    .irq_req    (irq_req)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%08h exp=%08h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, compare at next negedge.
  task automatic step(input bit we, input logic [31:0] wd, input logic [6:0] dn, input string tag);
    logic [31:0] nreg;
    logic        nm;
    wr_en = we; wr_data = wd; done_pulse = dn;
    nreg = m_reg;
    if (we) begin
      nreg = (nreg & 32'h7F000000 & ~wd) | (wd & 32'h00FF803F);
    end
    for (int i = 0; i < 7; i++)
      if (dn[i] && nreg[16+i]) nreg[24+i] = 1'b1;
    nm = (nreg[23] && nreg[30:24] != 0) || nreg[15];
    m_irq = nm && !m_reg[31];
    nreg[31] = nm;
    m_reg = nreg;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; done_pulse = '0;
    chk(tag, "rd_data", rd_data, m_reg);
    chk(tag, "irq_req", {31'd0, irq_req}, {31'd0, m_irq});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rd", rd_data, 32'h0);
    chk("R1", "reset irq", {31'd0, irq_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 32'hFFFFFFFF, 7'h00, "R2");
    chk("R2", "all-ones write", rd_data, 32'h80FF803F);
    chk("R7", "first rise", {31'd0, irq_req}, 32'h1);
    step(0, 32'h0, 7'h00, "R7");
    chk("R7", "no repeat", {31'd0, irq_req}, 32'h0);
    step(1, 32'h00800000, 7'h00, "R8");
    chk("R8", "master drops", rd_data, 32'h00800000);
    step(0, 32'h0, 7'h7F, "R4");
    chk("R4", "disabled pulse", rd_data, 32'h00800000);
    step(1, 32'h00850000, 7'h7F, "R4");
    chk("R4", "post-write enable", rd_data, 32'h85850000);
    chk("R7", "rise on flag", {31'd0, irq_req}, 32'h1);
    step(0, 32'h0, 7'h04, "R7");
    chk("R7", "held high no pulse", {31'd0, irq_req}, 32'h0);
    step(1, 32'h01850000, 7'h00, "R3");
    chk("R3", "w1c one flag", rd_data, 32'h84850000);
    step(1, 32'h04850000, 7'h04, "R5");
    chk("R5", "set beats clear", rd_data, 32'h84850000);
    step(1, 32'h04850000, 7'h00, "R8");
    chk("R8", "last flag cleared", rd_data, 32'h00850000);
    step(1, 32'h00050000, 7'h01, "R6");
    chk("R6", "gen off flag set", rd_data, 32'h01050000);
    chk("R6", "no irq gen off", {31'd0, irq_req}, 32'h0);
    step(1, 32'h00850000, 7'h00, "R8");
    chk("R8", "re-arm via gen", rd_data, 32'h81850000);
    chk("R8", "second rise", {31'd0, irq_req}, 32'h1);
    step(1, 32'h80858000, 7'h00, "R6");
    chk("R6", "bit31 write ignored", rd_data, 32'h81858000);
    chk("R7", "force while set", {31'd0, irq_req}, 32'h0);
    step(1, 32'h01007FC0, 7'h00, "R2");
    chk("R2", "reserved ignored", rd_data, 32'h00000000);

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] wd;
      logic [6:0]  dn;
      wd = $urandom;
      if ($urandom_range(0, 3) != 0) wd[30:24] = 7'd0;
      dn = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'd0;
      step(($urandom_range(0, 2) == 0), wd, dn, "R6");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule